// File: doc/BRIEF.md
# BCD Calendar Timekeeping Register Bank

This block is the timekeeping core of a real-time clock. It holds the current date and time as packed BCD bytes (seconds, minutes, hour, day of month, month, two-digit year, a binary weekday and a BCD century) and advances them by one second on each pulse of a one-pulse-per-second tick. Carries ripple through every field, with month lengths and leap years (including the century rule) handled in hardware. The hour byte carries its own mode flag that selects a 24-hour count or a 12-hour count with an afternoon bit.

Software reaches the bank through a byte-wide port addressed by a 16-bit register address. Reads are combinational. Writes form bursts: each byte goes into a staging copy, and the byte marked as last copies the whole staged set into the live registers in one cycle, so a time update can never be torn by a tick. A tick that arrives while a burst is open is held and applied the cycle after the burst completes. A clock-failure status bit is set by reset and is cleared only by a completed burst that wrote at least one time register.

Top module: `rtc_bcd_bank`

## Requirements
- R1: After reset the time bytes read seconds 0x00, minutes 0x00, hour 0x80, date 0x01, month 0x01, year 0x00, weekday 0x00, century 0x20, and the status byte reads 0x01.
- R2: Address 0x30+i (i = 0..7) reads, in order, seconds, minutes, hour, date, month, year, weekday, century; address 0x3F reads the status byte with the clock-failure flag in bit 0 and zeros above; every other address reads 0x00.
- R3: A tick advances seconds by one in BCD; seconds 0x59 becomes 0x00 and carries into minutes, and minutes 0x59 becomes 0x00 with a carry into the hour.
- R4: With hour bit 7 set (24-hour mode) the hour counts BCD 0x00 to 0x23 in bits 5:0, and 0x23 wraps to 0x00 with a carry into the date; bit 6 of the hour byte always reads 0.
- R5: With hour bit 7 clear (12-hour mode) bits 4:0 hold BCD 1 to 12 and bit 5 is the afternoon flag; 11 becomes 12 and toggles bit 5, 12 becomes 1, and only the 11 PM to 12 AM step carries into the date.
- R6: The date wraps to 0x01 after the last day of the month: 30 days for months 4, 6, 9, 11, 31 for the others, and for February 29 when the year is a multiple of four except year 00 of a century not divisible by four (so 2000 is leap, 1900 is not), otherwise 28.
- R7: The weekday (bits 2:0, binary 0..6, bits 7:3 read 0) increments modulo 7 on every date advance.
- R8: Month 0x12 wraps to 0x01 and carries into the year; year 0x99 wraps to 0x00 and increments the BCD century.
- R9: Written bytes are staged; the live time does not change while a burst is open, the byte written with wr_last set loads all staged bytes at once, and bytes not written in the burst keep their values.
- R10: Ticks that arrive while a burst is open or a byte is being written are held as one pending advance, applied on the first cycle with no write activity; several held ticks give one advance.
- R11: The clock-failure flag is set by reset and cleared only by a completed burst that wrote a time register; writes to the status address do not change it.
- R12: Writes to addresses outside 0x30..0x37 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| addr | input | 16 | Register address for reads and writes |
| wr_en | input | 1 | Write the byte on wr_data to addr this cycle |
| wr_data | input | 8 | Write data |
| wr_last | input | 1 | With wr_en: this byte ends the burst and commits it |
| rd_data | output | 8 | Combinational read of the register at addr |

## Verification
The bench aims at the carry chain edges: New Year of 1999 into 2000, February 28 in 1900, 2000, 2023 and 2024, a 30-day month end, the 2099 century roll and both 12-hour noon and midnight steps; a wrong leap rule shows as a date of 0x29 in a non-leap February or a skipped 29th, and a wrong 12-hour step shows as an hour of 0x13 or a date that moves at noon. Ticks are driven into open bursts, where a design that is not atomic would expose a half-written time or lose or double the held second. It also checks that status and unmapped writes leave the failure flag and time untouched, and that a one-byte burst leaves the other fields alone.

// File: rtl/rtc_bank_pkg.sv
// Shared constants, the time vector type and BCD helpers for the RTC bank.
// Assumes every stored time byte is valid BCD except the binary weekday.
package rtc_bank_pkg;
    localparam int NREG  = 8;
    localparam int IDX_W = $clog2(NREG);

    localparam int IX_SEC  = 0;
    localparam int IX_MIN  = 1;
    localparam int IX_HOUR = 2;
    localparam int IX_DATE = 3;
    localparam int IX_MON  = 4;
    localparam int IX_YEAR = 5;
    localparam int IX_WDAY = 6;
    localparam int IX_CEN  = 7;

    typedef logic [NREG-1:0][7:0] tm_t;

    // Increment a two-digit BCD byte (caller handles the wrap)
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    // Binary value of a two-digit BCD byte
    function automatic logic [6:0] bcd_val(input logic [7:0] v);
        return {3'b000, v[7:4]} * 7'd10 + {3'b000, v[3:0]};
    endfunction

    // Bits kept when a byte is written to a given time slot
    function automatic logic [7:0] field_mask(input int i);
        if (i == IX_HOUR) return 8'hBF;
        if (i == IX_WDAY) return 8'h07;
        return 8'hFF;
    endfunction
endpackage

// File: rtl/rtc_month_len.sv
// Last day of the month in BCD for a given month, year and century.
// Assumes BCD inputs; a year of 00 is leap only when the century is a multiple of 4.
module rtc_month_len
    import rtc_bank_pkg::*;
(
    input  logic [7:0] month,
    input  logic [7:0] year,
    input  logic [7:0] century,
    output logic [7:0] last_day
);
    logic [6:0] yb;
    logic [6:0] cb;
    logic       leap;

    // Leap decision from the binary year and century
    always_comb begin
        yb   = bcd_val(year);
        cb   = bcd_val(century);
        leap = ((yb % 7'd4) == 7'd0) && ((yb != 7'd0) || ((cb % 7'd4) == 7'd0));
    end

    // Month length lookup
    always_comb begin
        case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_time_adv.sv
// Combinational one-second advance of a full BCD time vector.
// Assumes valid field values; the hour byte bit 7 selects 24-hour counting.
module rtc_time_adv
    import rtc_bank_pkg::*;
(
    input  tm_t cur,
    output tm_t nxt
);
    logic [7:0] last_day;
    logic       c_s, c_m, c_h, c_d, c_mo, c_y;
    logic [7:0] hv, h12, h_inc;
    logic       pm;

    rtc_month_len u_mlen (
        .month   (cur[IX_MON]),
        .year    (cur[IX_YEAR]),
        .century (cur[IX_CEN]),
        .last_day(last_day)
    );

    // Carry chain from seconds up to century
    always_comb begin
        nxt   = cur;
        hv    = cur[IX_HOUR] & 8'h3F;
        h12   = cur[IX_HOUR] & 8'h1F;
        pm    = cur[IX_HOUR][5];
        h_inc = 8'h00;
        c_h   = 1'b0;

        c_s = cur[IX_SEC] >= 8'h59;
        nxt[IX_SEC] = c_s ? 8'h00 : bcd_inc(cur[IX_SEC]);

        c_m = c_s && (cur[IX_MIN] >= 8'h59);
        if (c_s) nxt[IX_MIN] = c_m ? 8'h00 : bcd_inc(cur[IX_MIN]);

        if (c_m) begin
            if (cur[IX_HOUR][7]) begin
                c_h   = hv >= 8'h23;
                h_inc = bcd_inc(hv);
                nxt[IX_HOUR] = c_h ? 8'h80 : (h_inc | 8'h80);
            end else if (h12 == 8'h11) begin
                c_h = pm;
                nxt[IX_HOUR] = {2'b00, ~pm, 5'h12};
            end else if (h12 >= 8'h12) begin
                nxt[IX_HOUR] = {2'b00, pm, 5'h01};
            end else begin
                h_inc = bcd_inc(h12);
                nxt[IX_HOUR] = h_inc | {2'b00, pm, 5'h00};
            end
        end

        c_d = c_h && (cur[IX_DATE] >= last_day);
        if (c_h) begin
            nxt[IX_DATE] = c_d ? 8'h01 : bcd_inc(cur[IX_DATE]);
            nxt[IX_WDAY] = (cur[IX_WDAY] >= 8'd6) ? 8'd0 : cur[IX_WDAY] + 8'd1;
        end

        c_mo = c_d && (cur[IX_MON] >= 8'h12);
        if (c_d) nxt[IX_MON] = c_mo ? 8'h01 : bcd_inc(cur[IX_MON]);

        c_y = c_mo && (cur[IX_YEAR] >= 8'h99);
        if (c_mo) nxt[IX_YEAR] = c_y ? 8'h00 : bcd_inc(cur[IX_YEAR]);

        if (c_y) nxt[IX_CEN] = (cur[IX_CEN] >= 8'h99) ? 8'h00 : bcd_inc(cur[IX_CEN]);
    end

    // Guards on the advanced seconds and weekday
    always_comb begin
        if (cur[IX_SEC] == 8'h59)
            assert_sec_wrap_R3: assert (nxt[IX_SEC] == 8'h00);
        if (cur[IX_WDAY] < 8'd7)
            assert_wday_range_R7: assert (nxt[IX_WDAY] < 8'd7);
    end
endmodule

// File: rtl/rtc_wr_stage.sv
// Write staging for the time bytes: collects a burst and hands a commit to the bank.
// Assumes the bank loads commit_tm in the cycle commit is high.
module rtc_wr_stage
    import rtc_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  tm_t              live,
    input  logic             wr_en,
    input  logic             wr_last,
    input  logic             hit,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wr_data,
    output logic             open,
    output logic             commit,
    output logic             commit_touch,
    output tm_t              commit_tm
);
    tm_t  stage;
    tm_t  base;
    logic touched;
    logic touch_c;

    // Start a burst from the live time, continue from the staged copy
    always_comb begin
        base    = open ? stage : live;
        touch_c = (open && touched) || hit;
    end

    // Replace the addressed byte in the merged vector
    for (genvar g = 0; g < NREG; g++) begin : g_merge
        assign commit_tm[g] = (hit && (idx == IDX_W'(g))) ? (wr_data & field_mask(g)) : base[g];
    end

    assign commit       = wr_en && wr_last;
    assign commit_touch = touch_c;

    // Burst state: open flag, staged bytes, time-write record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open    <= 1'b0;
            touched <= 1'b0;
            stage   <= '0;
        end else if (wr_en) begin
            if (wr_last) begin
                open    <= 1'b0;
                touched <= 1'b0;
            end else begin
                open    <= 1'b1;
                touched <= touch_c;
                stage   <= commit_tm;
            end
        end
    end
endmodule

// File: rtl/rtc_bcd_bank.sv
// RTC register bank: live BCD time, tick advance, staged burst writes, failure flag.
// Assumes sec_tick pulses at most about once per second; one held tick is kept.
module rtc_bcd_bank
    import rtc_bank_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]    TIME_BASE = 'h30,
    parameter logic [ADDR_W-1:0]    STAT_ADDR = 'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              wr_last,
    output logic [7:0]        rd_data
);
    localparam tm_t RESET_TM = {8'h20, 8'h00, 8'h00, 8'h01, 8'h01, 8'h80, 8'h00, 8'h00};

    tm_t              live;
    tm_t              adv_tm;
    tm_t              commit_tm;
    logic [ADDR_W-1:0] off;
    logic             in_range;
    logic [IDX_W-1:0] idx;
    logic             stg_open, commit, commit_touch;
    logic             busy, pend, go, fail;

    // Address decode into the time window
    always_comb begin
        off      = addr - TIME_BASE;
        in_range = off < ADDR_W'(NREG);
        idx      = off[IDX_W-1:0];
    end

    rtc_wr_stage u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .live        (live),
        .wr_en       (wr_en),
        .wr_last     (wr_last),
        .hit         (wr_en && in_range),
        .idx         (idx),
        .wr_data     (wr_data),
        .open        (stg_open),
        .commit      (commit),
        .commit_touch(commit_touch),
        .commit_tm   (commit_tm)
    );

    rtc_time_adv u_adv (
        .cur(live),
        .nxt(adv_tm)
    );

    assign busy = stg_open || wr_en;
    assign go   = (sec_tick || pend) && !busy;

    // Held tick while a write is in progress
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (busy) pend <= pend || sec_tick;
        else           pend <= 1'b0;
    end

    // Live time: commit has priority, ticks advance otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)      live <= RESET_TM;
        else if (commit) live <= commit_tm;
        else if (go)     live <= adv_tm;
    end

    // Clock-failure flag: set by reset, cleared by a committed time write
    always_ff @(posedge clk) begin
        if (!rst_n)                       fail <= 1'b1;
        else if (commit && commit_touch)  fail <= 1'b0;
    end

    // Read multiplexer
    always_comb begin
        rd_data = 8'h00;
        if (in_range)               rd_data = live[idx];
        else if (addr == STAT_ADDR) rd_data = {7'd0, fail};
    end

    assert_hold_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_open && !wr_en) |=> $stable(live));
    assert_pend_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sec_tick) |=> pend);
    assert_fail_no_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(fail));
    assert_fail_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && commit_touch) |=> !fail);
endmodule

// File: tb/rtc_bcd_bank_test.sv
`timescale 1ns/1ps
module rtc_bcd_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [15:0] addr = 16'h0030;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        wr_last = 1'b0;
    logic [7:0]  rd_data;

    int    nchk = 0, nbad = 0, scan = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    rtc_bcd_bank uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    // Reference model: 0 sec,1 min,2 hour(0..23),3 date,4 month,5 year,6 wday,7 century,8 mode24
    int L[9];
    int S[9];
    int m_open, m_touch, m_pend, m_fail;
    bit busy;

    function automatic int bin_of(int b); return (b >> 4) * 10 + (b & 15); endfunction
    function automatic int bcd_of(int n); return ((n / 10) << 4) | (n % 10); endfunction

    function automatic int days_in(int mon, int yfull);
        if (mon == 2) return ((yfull % 4 == 0) && ((yfull % 100 != 0) || (yfull % 400 == 0))) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic int model_byte(int i);
        int h12;
        case (i)
            2: begin
                if (L[8] != 0) return 8'h80 | bcd_of(L[2]);
                h12 = (L[2] % 12 == 0) ? 12 : L[2] % 12;
                return ((L[2] >= 12) ? 32 : 0) | bcd_of(h12);
            end
            6: return L[6];
            default: return bcd_of(L[i == 0 ? 0 : i == 1 ? 1 : i == 3 ? 3 : i == 4 ? 4 : i == 5 ? 5 : 7]);
        endcase
    endfunction

    function automatic int read_exp(int a);
        if (a >= 48 && a < 56) return model_byte(a - 48);
        if (a == 63) return m_fail;
        return 0;
    endfunction

    task automatic put_byte(int i, int d);
        int h;
        case (i)
            2: begin
                S[8] = (d >> 7) & 1;
                if (S[8] != 0) S[2] = bin_of(d & 63);
                else begin h = bin_of(d & 31); S[2] = (h % 12) + (((d >> 5) & 1) != 0 ? 12 : 0); end
            end
            6: S[6] = d & 7;
            default: S[i] = bin_of(d);
        endcase
    endtask

    task automatic advance();
        L[0]++;
        if (L[0] == 60) begin
            L[0] = 0; L[1]++;
            if (L[1] == 60) begin
                L[1] = 0; L[2]++;
                if (L[2] == 24) begin
                    L[2] = 0; L[6] = (L[6] + 1) % 7; L[3]++;
                    if (L[3] > days_in(L[4], L[7] * 100 + L[5])) begin
                        L[3] = 1; L[4]++;
                        if (L[4] > 12) begin
                            L[4] = 1; L[5]++;
                            if (L[5] > 99) begin L[5] = 0; L[7] = (L[7] + 1) % 100; end
                        end
                    end
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            L = '{0, 0, 0, 1, 1, 0, 0, 20, 1};
            m_open = 0; m_touch = 0; m_pend = 0; m_fail = 1;
        end else begin
            busy = (m_open != 0) || wr_en;
            if (wr_en) begin
                if (m_open == 0) begin S = L; m_touch = 0; end
                if (addr >= 16'h30 && addr < 16'h38) begin put_byte(int'(addr) - 48, int'(wr_data)); m_touch = 1; end
                if (wr_last) begin L = S; if (m_touch != 0) m_fail = 0; m_open = 0; end
                else m_open = 1;
            end
            if (busy) m_pend = m_pend | int'(sec_tick);
            else begin
                if (sec_tick || m_pend != 0) advance();
                m_pend = 0;
            end
        end
    end

    task automatic scan_check();
        int e;
        if (!rst_n) return;
        e = read_exp(int'(addr));
        nchk++;
        if (rd_data !== e[7:0]) begin
            nbad++;
            $display("FAIL %s model compare addr=%h actual=%h expected=%h", cur_req, addr, rd_data, e[7:0]);
        end
    endtask

    task automatic cyc(int a, bit we, int d, bit last, bit tk);
        @(negedge clk);
        scan_check();
        addr = a[15:0]; wr_en = we; wr_data = d[7:0]; wr_last = last; sec_tick = tk;
    endtask

    task automatic idle(int n, bit tk);
        for (int i = 0; i < n; i++) begin
            cyc((scan % 9 == 8) ? 63 : 48 + scan % 9, 1'b0, 0, 1'b0, tk);
            scan++;
        end
    endtask

    task automatic peek(int a, int e, string req);
        @(negedge clk);
        addr = a[15:0]; wr_en = 1'b0; wr_last = 1'b0; sec_tick = 1'b0;
        #0.5;
        nchk++;
        if (rd_data !== e[7:0]) begin
            nbad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, rd_data, e[7:0]);
        end
    endtask

    task automatic set_time(int s, int mi, int h, int dt, int mo, int y, int w, int c, int tmask);
        int v[8];
        v = '{s, mi, h, dt, mo, y, w, c};
        for (int i = 0; i < 8; i++) cyc(48 + i, 1'b1, v[i], i == 7, tmask[i]);
    endtask

    task automatic tick(); cyc(48, 1'b0, 0, 1'b0, 1'b1); endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        idle(3, 1'b0);
        rst_n = 1'b1;
        // R1 reset state
        peek(48, 8'h00, "R1 sec"); peek(49, 8'h00, "R1 min"); peek(50, 8'h80, "R1 hour");
        peek(51, 8'h01, "R1 date"); peek(52, 8'h01, "R1 month"); peek(53, 8'h00, "R1 year");
        peek(54, 8'h00, "R1 wday"); peek(55, 8'h20, "R1 century"); peek(63, 8'h01, "R1 status");
        // R2 unmapped reads
        peek(16'h38, 8'h00, "R2 0x38"); peek(16'h2F, 8'h00, "R2 0x2F"); peek(16'h1030, 8'h00, "R2 0x1030");
        // R11 status write ignored, R12 stray writes ignored
        cur_req = "R11";
        cyc(63, 1'b1, 0, 1'b1, 1'b0);
        peek(63, 8'h01, "R11 status write");
        cur_req = "R12";
        cyc(16'h40, 1'b1, 8'h55, 1'b1, 1'b0); cyc(16'h2F, 1'b1, 8'h55, 1'b1, 1'b0);
        peek(48, 8'h00, "R12 sec"); peek(51, 8'h01, "R12 date"); peek(63, 8'h01, "R12 status");
        // R8 New Year into 2000
        cur_req = "R8";
        set_time(8'h58, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 6, 8'h19, 0);
        peek(63, 8'h00, "R11 cleared");
        tick(); peek(48, 8'h59, "R3 sec");
        tick();
        peek(48, 8'h00, "R3 sec wrap"); peek(49, 8'h00, "R3 min wrap"); peek(50, 8'h80, "R4 hour wrap");
        peek(51, 8'h01, "R6 date"); peek(52, 8'h01, "R8 month"); peek(53, 8'h00, "R8 year");
        peek(54, 8'h00, "R7 wday"); peek(55, 8'h20, "R8 century");
        // R6 leap rules
        cur_req = "R6";
        set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h00, 1, 8'h20, 0); tick();
        peek(51, 8'h29, "R6 2000 leap"); peek(54, 8'h02, "R7 wday");
        set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h00, 3, 8'h19, 0); tick();
        peek(51, 8'h01, "R6 1900 date"); peek(52, 8'h03, "R6 1900 month");
        set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h23, 2, 8'h20, 0); tick();
        peek(52, 8'h03, "R6 2023 month");
        set_time(8'h59, 8'h59, 8'hA3, 8'h29, 8'h02, 8'h24, 4, 8'h20, 0); tick();
        peek(51, 8'h01, "R6 2024 date"); peek(52, 8'h03, "R6 2024 month");
        set_time(8'h59, 8'h59, 8'hA3, 8'h30, 8'h04, 8'h23, 6, 8'h20, 0); tick();
        peek(51, 8'h01, "R6 april"); peek(52, 8'h05, "R6 april month"); peek(54, 8'h00, "R7 wrap");
        // R5 12-hour steps
        cur_req = "R5";
        set_time(8'h59, 8'h59, 8'h11, 8'h15, 8'h06, 8'h23, 2, 8'h20, 0); tick();
        peek(50, 8'h32, "R5 noon"); peek(51, 8'h15, "R5 noon date");
        set_time(8'h59, 8'h59, 8'h31, 8'h15, 8'h06, 8'h23, 2, 8'h20, 0); tick();
        peek(50, 8'h12, "R5 midnight"); peek(51, 8'h16, "R5 midnight date"); peek(54, 8'h03, "R7 12h");
        set_time(8'h59, 8'h59, 8'h32, 8'h15, 8'h06, 8'h23, 2, 8'h20, 0); tick();
        peek(50, 8'h21, "R5 one pm");
        // R8 century roll
        cur_req = "R8";
        set_time(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 5, 8'h20, 0); tick();
        peek(53, 8'h00, "R8 year 00"); peek(55, 8'h21, "R8 century 21");
        // R4 bit 6 / R7 upper bits masked
        cur_req = "R4";
        set_time(8'h00, 8'h00, 8'hC5, 8'h10, 8'h03, 8'h23, 8'hFE, 8'h20, 0);
        peek(50, 8'h85, "R4 bit6"); peek(54, 8'h06, "R7 mask");
        // R9 and R10: burst with ticks inside, live stays put mid-burst
        cur_req = "R10";
        cyc(48, 1'b1, 8'h10, 1'b0, 1'b1); cyc(49, 1'b1, 8'h20, 1'b0, 1'b1);
        peek(48, 8'h00, "R9 mid burst");
        cyc(50, 1'b1, 8'h85, 1'b0, 1'b1); cyc(51, 1'b1, 8'h10, 1'b0, 1'b0);
        cyc(52, 1'b1, 8'h03, 1'b0, 1'b0); cyc(53, 1'b1, 8'h23, 1'b0, 1'b0);
        cyc(54, 1'b1, 8'h05, 1'b0, 1'b0); cyc(55, 1'b1, 8'h20, 1'b1, 1'b1);
        peek(48, 8'h10, "R9 commit"); peek(48, 8'h11, "R10 held tick");
        peek(48, 8'h11, "R10 single advance");
        // R9 one-byte burst keeps others
        cur_req = "R9";
        cyc(49, 1'b1, 8'h45, 1'b1, 1'b0);
        peek(49, 8'h45, "R9 minute"); peek(48, 8'h11, "R9 sec kept"); peek(51, 8'h10, "R9 date kept");
        // long runs against the model
        cur_req = "R3 R4";
        set_time(8'h00, 8'h58, 8'hA3, 8'h31, 8'h12, 8'h23, 0, 8'h20, 8'h09);
        idle(4000, 1'b1);
        cur_req = "R5 R10";
        set_time(8'h00, 8'h58, 8'h31, 8'h28, 8'h02, 8'h24, 3, 8'h20, 8'hFF);
        idle(4000, 1'b1);
        idle(20, 1'b0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule